// File: doc/BRIEF.md
# I/Q Sample Input Conditioner

This stage sits between a pair of 6-bit A/D converters and the carrier recovery loop of a digital demodulator. Each accepted sample pair is read either as offset binary or as two's complement, chosen by a static control input. The pair is then optionally exchanged between the I and Q rails. A slowly tracking DC estimate is subtracted from each rail, so that converter offsets and leakage from the local oscillator do not reach the mixer.

The DC estimate on each rail is a first-order leaky integrator. A 3-bit setting selects how fast it tracks, with a shift from 4 to 11. Results come out as 7-bit signed values with a valid flag. The pipeline has two register stages and a fixed latency.

Top module: `iq_input_conditioner`

## Requirements
- R1: When `fmt_offset` is 1, each 6-bit input code c is read as the signed value c − 32 (MSB inverted). Code 0x20 means 0, code 0x00 means −32 and code 0x3F means +31.
- R2: When `fmt_offset` is 0, each input code is read as a 6-bit two's complement value.
- R3: When `swap_iq` is 1, the converted I input feeds the Q rail and the converted Q input feeds the I rail. The swap happens before DC removal, so each output rail's DC estimate tracks the samples routed to that rail.
- R4: `out_valid` is high in exactly the cycle two clock edges after an edge at which `in_valid` was sampled high, and at no other time.
- R5: Each rail holds a DC accumulator `a`, scaled by 2^11. For each valid sample x it updates to a + ((x·2^11 − a) >>> k), where >>> is an arithmetic (floor) shift and k = 4 + `dc_shift`. It stays unchanged when no sample is processed, and it never leaves the range [−32·2^11, 31·2^11].
- R6: Each output equals x − floor(a / 2^11), using the accumulator value before that sample's update, clamped to the 7-bit signed range [−64, 63].
- R7: A synchronous reset (`rst` high at a clock edge) clears both accumulators and both outputs to zero and drives `out_valid` low.
- R8: `out_i` and `out_q` keep their values in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample pair valid |
| in_i | input | 6 | Raw I converter code |
| in_q | input | 6 | Raw Q converter code |
| fmt_offset | input | 1 | 1: offset binary, 0: two's complement |
| swap_iq | input | 1 | 1: exchange I and Q rails |
| dc_shift | input | 3 | DC tracking shift, k = 4 + value |
| out_valid | output | 1 | Output sample pair valid |
| out_i | output | 7 | DC-free signed I sample |
| out_q | output | 7 | DC-free signed Q sample |

## Verification
Some properties are checked on every cycle by assertions. These are the two-cycle valid alignment, the output hold while `out_valid` is low, the freeze of the accumulators between samples, the bound on accumulator range, and the clearing by reset. The arithmetic can only be shown by the bench's scenarios, where a scoreboard model computes every expected value from the requirements. That arithmetic covers the offset-binary and two's complement readings, the rail exchange, the integrator's convergence at several shift settings and output values at the extremes of the range.

// File: rtl/iq_input_conditioner.sv
module iq_input_conditioner #(
  parameter int W    = 6,
  parameter int KW   = 3,
  parameter int KMIN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [W-1:0]        in_i,
  input  logic [W-1:0]        in_q,
  input  logic                fmt_offset,
  input  logic                swap_iq,
  input  logic [KW-1:0]       dc_shift,
  output logic                out_valid,
  output logic signed [W:0]   out_i,
  output logic signed [W:0]   out_q
);
  localparam int FRAC = KMIN + (1 << KW) - 1;
  localparam int OW   = W + 1;
  localparam int AW   = W + FRAC + 1;
  localparam int SW   = $clog2(FRAC + 1);
  localparam logic signed [AW-1:0] ACC_MAX = AW'((2 ** (W - 1) - 1) * (2 ** FRAC));
  localparam logic signed [AW-1:0] ACC_MIN = -AW'((2 ** (W - 1)) * (2 ** FRAC));

  logic [W-1:0] conv_i, conv_q;
  assign conv_i = fmt_offset ? {~in_i[W-1], in_i[W-2:0]} : in_i;
  assign conv_q = fmt_offset ? {~in_q[W-1], in_q[W-2:0]} : in_q;

  logic                v1;
  logic signed [W-1:0] s1  [2];
  logic signed [AW-1:0] acc [2];
  logic signed [OW-1:0] res [2];
  logic signed [AW-1:0] nxt [2];
  logic [SW-1:0] k;

  assign k = SW'(KMIN) + SW'(dc_shift);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      s1[0] <= '0;
      s1[1] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        s1[0] <= swap_iq ? conv_q : conv_i;
        s1[1] <= swap_iq ? conv_i : conv_q;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < 2; r++) begin
      logic signed [AW-1:0] tgt;
      logic signed [AW-1:0] dc;
      logic signed [OW:0]   d;
      tgt = {{(FRAC + 1){s1[r][W-1]}}, s1[r]} <<< FRAC;
      nxt[r] = acc[r] + ((tgt - acc[r]) >>> k);
      dc = acc[r] >>> FRAC;
      d = {{2{s1[r][W-1]}}, s1[r]} - dc[OW:0];
      if (d[OW] != d[OW-1])
        res[r] = d[OW] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
      else
        res[r] = d[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      acc[0]    <= '0;
      acc[1]    <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_i  <= res[0];
        out_q  <= res[1];
        acc[0] <= nxt[0];
        acc[1] <= nxt[1];
      end
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  assert_pipe_R4: assert property (@(posedge clk) disable iff (rst)
    v1 |=> out_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> $stable(out_i) && $stable(out_q));
  assert_acc_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> $stable(acc[0]) && $stable(acc[1]));
  assert_acc_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    acc[0] >= ACC_MIN && acc[0] <= ACC_MAX && acc[1] >= ACC_MIN && acc[1] <= ACC_MAX);
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> acc[0] == '0 && acc[1] == '0 && !out_valid && out_i == '0 && out_q == '0);
endmodule

// File: tb/sim_iq_input_conditioner.sv
module sim_iq_input_conditioner;
  logic clk = 0, rst = 1, in_valid = 0, fmt_offset = 0, swap_iq = 0;
  logic [5:0] in_i = 0, in_q = 0;
  logic [2:0] dc_shift = 0;
  logic out_valid;
  logic signed [6:0] out_i, out_q;

  iq_input_conditioner u0 (.clk, .rst, .in_valid, .in_i, .in_q, .fmt_offset,
    .swap_iq, .dc_shift, .out_valid, .out_i, .out_q);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  longint acc_m [2];
  int exp_i[$], exp_q[$], exp_c[$];
  int last_i = 0, last_q = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int readv(logic [5:0] c);
    if (fmt_offset) return int'(c) - 32;
    return int'($signed(c));
  endfunction

  function automatic int rail(int r, int x);
    longint dc, o;
    dc = acc_m[r] >>> 11;
    o = x - dc;
    if (o > 63) o = 63;
    if (o < -64) o = -64;
    acc_m[r] = acc_m[r] + (((longint'(x) <<< 11) - acc_m[r]) >>> (4 + dc_shift));
    return int'(o);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] ci, logic [5:0] cq);
    int a, b;
    @(negedge clk);
    in_valid = 1; in_i = ci; in_q = cq;
    a = readv(ci); b = readv(cq);
    if (swap_iq) begin int t = a; a = b; b = t; end
    exp_i.push_back(rail(0, a));
    exp_q.push_back(rail(1, b));
    exp_c.push_back(cyc + 2);
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_i.size() == 0) check(0, "R4 unexpected valid", 1, 0);
        else begin
          int ei, eq, ec;
          ei = exp_i.pop_front(); eq = exp_q.pop_front(); ec = exp_c.pop_front();
          check(cyc == ec, "R4 latency", cyc, ec);
          check(int'(out_i) == ei, "R1/R2/R3/R5/R6 out_i", out_i, ei);
          check(int'(out_q) == eq, "R1/R2/R3/R5/R6 out_q", out_q, eq);
          last_i = out_i; last_q = out_q;
        end
      end else begin
        check(int'(out_i) == last_i && int'(out_q) == last_q, "R8 hold", out_i, last_i);
      end
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R7 reset valid", out_valid, 0);
    check(out_i == 0 && out_q == 0, "R7 reset outputs", out_i, 0);
    rst = 0;
    acc_m[0] = 0; acc_m[1] = 0;
    // R2: two's complement, constant DC, k=4
    for (int n = 0; n < 60; n++) drive(6'd10, 6'h3B);
    idle(4);
    // R1: offset binary extremes and midpoint
    fmt_offset = 1;
    drive(6'h20, 6'h20); drive(6'h00, 6'h3F); drive(6'h3F, 6'h00);
    for (int n = 0; n < 30; n++) drive(6'h3F, 6'h00);
    idle(4);
    // R3: swapped rails
    swap_iq = 1;
    for (int n = 0; n < 30; n++) drive(6'h30, 6'h08);
    idle(4);
    // R5/R6: slow tracking, full-swing alternation with gaps (R8)
    swap_iq = 0; fmt_offset = 0; dc_shift = 3'd7;
    lf = 32'h1ACE;
    for (int n = 0; n < 200; n++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
      if (lf[0]) drive(n[0] ? 6'h1F : 6'h20, n[0] ? 6'h20 : 6'h1F);
      else idle(1 + (lf[2:1]));
    end
    idle(4);
    dc_shift = 3'd2;
    for (int n = 0; n < 80; n++) drive(6'(n * 7), 6'(n * 13 + 5));
    idle(4);
    // R7: reset mid-run clears accumulators
    @(negedge clk); rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 0 && out_i == 0 && out_q == 0, "R7 reset clears", out_i, 0);
    rst = 0; acc_m[0] = 0; acc_m[1] = 0; last_i = 0; last_q = 0;
    drive(6'h25, 6'h05); drive(6'h25, 6'h05);
    idle(5);
    check(exp_i.size() == 0, "R4 all outputs seen", exp_i.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule